// File: doc/BRIEF.md
# SMI Event Status and Enable Controller

This block collects five system-management events into a status register and raises one system-management interrupt request when any recorded event is also enabled. The events are a sleep command written to the power-control register, a rising edge on the boot-ROM write-enable control bit, a strobe from the serial-interrupt decoder, a one-minute periodic tick and a 64 ms periodic tick. Software reads both registers through a small register port. It clears status bits by writing ones to them and sets its enables by writing the enable register.

The block holds both periodic timers. Each timer counts pulses of an external 1 ms timebase strobe, and its period is a parameter, so a bench can use short periods. The one-minute timer runs only while the full-on power state input is high. The 64 ms timer runs only while its enable bit is set. When the sleep-command enable is set, a sleep command is trapped: the status bit is recorded, but the power-change pulse that would let the sequencer act is withheld. Software then clears the status and the enable, and issues the command again.

Top module: `smi_event_ctrl`

## Requirements
- R1: After reset, the status register reads 0000h, the enable register reads 0000h, `smi` is 0 and `pwr_change` is 0.
- R2: With `reg_addr`=0, `reg_rdata` returns the status register; with `reg_addr`=1 it returns the enable register. Bit positions are: 0 sleep command, 1 ROM write-enable, 2 serial-IRQ SMI, 3 one-minute, 4 64 ms. Bits 15:5 always read 0.
- R3: A status write clears every status bit whose written data bit is 1. Status bits whose written data bit is 0 keep their value.
- R4: `smi` is registered. It is 1 in the cycle after any status bit and the enable bit at the same position are both 1 at a clock edge, and 0 otherwise.
- R5: A power-control write (`pwr_wr`) with `pwr_wdata[13]`=1 sets status bit 0. If enable bit 0 is 0, `pwr_change` pulses high for exactly one cycle after that edge. If enable bit 0 is 1, `pwr_change` stays 0. A power-control write with bit 13 low has no effect.
- R6: Status bit 1 is set only when `rom_we` goes from 0 to 1. A level that stays high does not set it again.
- R7: Enable bit 1 can only be set by a write. Writing 0 to it leaves it at 1, and only reset clears it.
- R8: A one-cycle pulse on `sirq_smi` sets status bit 2.
- R9: While enable bit 4 is 1, status bit 4 is set on every MS64_TICKS-th `tick_1ms` pulse, and the timer keeps running after the bit is set. While enable bit 4 is 0, the count is held at zero.
- R10: While `full_on` is 1, status bit 3 is set on every MIN_TICKS-th `tick_1ms` pulse. While `full_on` is 0, the count is held at zero.
- R11: If a hardware set and a write-1-clear hit the same status bit in the same cycle, the bit ends up set.
- R12: Enable bits 0, 2, 3 and 4 take the written value on every enable write, ones and zeros alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low bus reset; clears all state, including the sticky enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for the selected register |
| pwr_wr | input | 1 | Write strobe to the power-control register |
| pwr_wdata | input | 16 | Power-control write data; bit 13 is the sleep request |
| rom_we | input | 1 | Level of the boot-ROM write-enable control bit |
| sirq_smi | input | 1 | SMI request pulse from the serial-interrupt decoder |
| full_on | input | 1 | High while the system is in the full-on power state |
| tick_1ms | input | 1 | One-cycle timebase strobe, once per millisecond |
| smi | output | 1 | Registered SMI request |
| pwr_change | output | 1 | One-cycle pulse that allows a sleep command to take effect |

## Verification
A hardware event and a software write-1-clear can land on the same status bit in the same cycle. The bench provokes this by pulsing `sirq_smi` on the same edge as a status write that carries a 1 in bit 2 and also a 1 in bit 1, which is already set. The result is judged by reading back that bit 2 stays set while bit 1 clears. The second collision is a sleep command that arrives while its enable is set, where the status capture and the power-change permission compete. The bench checks that the status bit is recorded and that `pwr_change` stays low, then repeats the command with the enable cleared and expects the pulse.

// File: rtl/smi_pkg.sv
package smi_pkg;
    localparam int REG_W     = 16;
    localparam int NUM_EV    = 5;
    localparam int EV_SLP    = 0;
    localparam int EV_ROM    = 1;
    localparam int EV_SIRQ   = 2;
    localparam int EV_MIN    = 3;
    localparam int EV_MS64   = 4;
    localparam int SLEEP_BIT = 13;

    typedef logic [NUM_EV-1:0] ev_vec_t;

    typedef struct packed {
        logic rom_lvl;
        logic smi;
        logic pwr_go;
    } top_state_t;
endpackage

// File: rtl/smi_period_timer.sv
module smi_period_timer #(
    parameter int PERIOD = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                expire   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9 / R10: count held at zero while stopped
    a_r9_held_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == '0));
    a_r10_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
endmodule

// File: rtl/smi_status_bank.sv
module smi_status_bank
    import smi_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clr_wr,
    input  ev_vec_t clr_mask,
    input  ev_vec_t set_vec,
    output ev_vec_t sts
);
    typedef struct packed {
        ev_vec_t bits;
    } sts_state_t;

    sts_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_wr) st_d.bits = st_d.bits & ~clr_mask;
        st_d.bits = st_d.bits | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts = st_q.bits;

    // R11: a hardware set is never lost to a simultaneous clear
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((st_q.bits & $past(set_vec)) == $past(set_vec)));
    // R3: bits neither set nor cleared hold their value
    a_r3_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr && set_vec == '0) |=> $stable(st_q.bits));
endmodule

// File: rtl/smi_enable_bank.sv
module smi_enable_bank
    import smi_pkg::*;
#(
    parameter ev_vec_t STICKY_MASK = ev_vec_t'(1 << EV_ROM)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr,
    input  ev_vec_t wdata,
    output ev_vec_t en
);
    typedef struct packed {
        ev_vec_t bits;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.bits = (wdata & ~STICKY_MASK)
                      | ((st_q.bits | wdata) & STICKY_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en = st_q.bits;

    // R7: once set, a sticky enable stays set until reset
    a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st_q.bits & STICKY_MASK)) |=>
        ((st_q.bits & $past(st_q.bits & STICKY_MASK)) == $past(st_q.bits & STICKY_MASK)));
    // R12: ordinary enables follow the written data
    a_r12_plain_follow: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ((st_q.bits & ~STICKY_MASK) == ($past(wdata) & ~STICKY_MASK)));
endmodule

// File: rtl/smi_event_ctrl.sv
module smi_event_ctrl
    import smi_pkg::*;
#(
    parameter int MS64_TICKS = 64,
    parameter int MIN_TICKS  = 60000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        pwr_wr,
    input  logic [15:0] pwr_wdata,
    input  logic        rom_we,
    input  logic        sirq_smi,
    input  logic        full_on,
    input  logic        tick_1ms,
    output logic        smi,
    output logic        pwr_change
);
    localparam int PAD_W = REG_W - NUM_EV;

    top_state_t st_d, st_q;
    ev_vec_t    sts, en, set_vec;
    logic       ms64_exp, min_exp, sleep_cmd, rom_rise;
    logic       sts_wr, en_wr;

    assign sts_wr    = reg_wr && (reg_addr == 1'b0);
    assign en_wr     = reg_wr && (reg_addr == 1'b1);
    assign sleep_cmd = pwr_wr && pwr_wdata[SLEEP_BIT];
    assign rom_rise  = rom_we && !st_q.rom_lvl;

    smi_period_timer #(.PERIOD(MS64_TICKS)) u_ms64 (
        .clk(clk), .rst_n(rst_n), .run(en[EV_MS64]),
        .tick(tick_1ms), .expire(ms64_exp)
    );

    smi_period_timer #(.PERIOD(MIN_TICKS)) u_min (
        .clk(clk), .rst_n(rst_n), .run(full_on),
        .tick(tick_1ms), .expire(min_exp)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[EV_SLP]   = sleep_cmd;
        set_vec[EV_ROM]   = rom_rise;
        set_vec[EV_SIRQ]  = sirq_smi;
        set_vec[EV_MIN]   = min_exp;
        set_vec[EV_MS64]  = ms64_exp;
    end

    smi_status_bank u_sts (
        .clk(clk), .rst_n(rst_n), .clr_wr(sts_wr),
        .clr_mask(reg_wdata[NUM_EV-1:0]), .set_vec(set_vec), .sts(sts)
    );

    smi_enable_bank u_en (
        .clk(clk), .rst_n(rst_n), .wr(en_wr),
        .wdata(reg_wdata[NUM_EV-1:0]), .en(en)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rom_lvl = rom_we;
        st_d.smi     = |(sts & en);
        st_d.pwr_go  = sleep_cmd && !en[EV_SLP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata  = {{PAD_W{1'b0}}, (reg_addr ? en : sts)};
    assign smi        = st_q.smi;
    assign pwr_change = st_q.pwr_go;

    // R4: an enabled pending event raises smi on the next cycle
    a_r4_smi_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sts & en)) |=> smi);
    a_r4_smi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(sts & en)) |=> !smi);
    // R5: a trapped sleep command never lets the power change through
    a_r5_sleep_trapped: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_cmd && en[EV_SLP]) |=> !pwr_change);
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_change && !sleep_cmd) |=> !pwr_change);
    // R2: reserved bits read as zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:NUM_EV] == '0);
endmodule

// File: tb/smi_event_ctrl_test.sv
module smi_event_ctrl_test;
    localparam int MS64 = 8;
    localparam int MINT = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic        pwr_wr = 1'b0;
    logic [15:0] pwr_wdata = '0;
    logic        rom_we = 1'b0, sirq_smi = 1'b0, full_on = 1'b0, tick_1ms = 1'b0;
    logic        smi, pwr_change;
    int          errors = 0, checks = 0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    smi_event_ctrl #(.MS64_TICKS(MS64), .MIN_TICKS(MINT)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_wr(pwr_wr),
        .pwr_wdata(pwr_wdata), .rom_we(rom_we), .sirq_smi(sirq_smi),
        .full_on(full_on), .tick_1ms(tick_1ms), .smi(smi), .pwr_change(pwr_change)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [15:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1ms = 1'b1;
            @(negedge clk);
            tick_1ms = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(1'b0, v); check("R1 status", v, 16'h0000);
        rd(1'b1, v); check("R1 enable", v, 16'h0000);
        check("R1 smi", {15'b0, smi}, 16'h0);
        check("R1 pwr_change", {15'b0, pwr_change}, 16'h0);
    endtask

    task automatic t_sirq_smi();
        logic [15:0] v;
        wr(1'b1, 16'hFFE4);
        rd(1'b1, v); check("R12 enable write / R2 reserved", v, 16'h0004);
        sirq_smi = 1'b1; @(negedge clk); sirq_smi = 1'b0;
        rd(1'b0, v); check("R8 sirq sets bit2", v, 16'h0004);
        check("R4 smi not yet", {15'b0, smi}, 16'h0);
        @(negedge clk);
        check("R4 smi raised", {15'b0, smi}, 16'h1);
        wr(1'b0, 16'h0000);
        rd(1'b0, v); check("R3 write 0 no effect", v, 16'h0004);
        wr(1'b0, 16'h0004);
        rd(1'b0, v); check("R3 w1c", v, 16'h0000);
        @(negedge clk);
        check("R4 smi dropped", {15'b0, smi}, 16'h0);
        wr(1'b1, 16'h0000);
        rd(1'b1, v); check("R12 enable cleared", v, 16'h0000);
    endtask

    task automatic t_rom();
        logic [15:0] v;
        rom_we = 1'b1; @(negedge clk);
        rd(1'b0, v); check("R6 rise sets bit1", v, 16'h0002);
        wr(1'b0, 16'h0002);
        repeat (3) @(negedge clk);
        rd(1'b0, v); check("R6 level does not reset", v, 16'h0000);
        rom_we = 1'b0; @(negedge clk);
        rom_we = 1'b1; @(negedge clk);
        rd(1'b0, v); check("R6 second rise", v, 16'h0002);
    endtask

    task automatic t_collision();
        logic [15:0] v;
        // bit1 already set from t_rom; clear bits 1 and 2 while sirq fires
        reg_addr = 1'b0; reg_wdata = 16'h0006; reg_wr = 1'b1; sirq_smi = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; sirq_smi = 1'b0;
        rd(1'b0, v); check("R11 set wins, other bit cleared", v, 16'h0004);
        wr(1'b0, 16'h0004);
        rd(1'b0, v); check("R3 cleared after collision", v, 16'h0000);
    endtask

    task automatic t_sleep();
        logic [15:0] v;
        pwr_wdata = 16'hDFFF; pwr_wr = 1'b1; @(negedge clk); pwr_wr = 1'b0;
        rd(1'b0, v); check("R5 no bit13 no status", v, 16'h0000);
        check("R5 no bit13 no pulse", {15'b0, pwr_change}, 16'h0);
        pwr_wdata = 16'h2000; pwr_wr = 1'b1; @(negedge clk); pwr_wr = 1'b0;
        rd(1'b0, v); check("R5 sleep status", v, 16'h0001);
        check("R5 pulse when not trapped", {15'b0, pwr_change}, 16'h1);
        @(negedge clk);
        check("R5 pulse one cycle", {15'b0, pwr_change}, 16'h0);
        wr(1'b0, 16'h0001);
        wr(1'b1, 16'h0001);
        pwr_wr = 1'b1; @(negedge clk); pwr_wr = 1'b0;
        rd(1'b0, v); check("R5 trapped status", v, 16'h0001);
        check("R5 trapped no pulse", {15'b0, pwr_change}, 16'h0);
        @(negedge clk);
        check("R5 trapped still no pulse / R4 smi", {14'b0, pwr_change, smi}, 16'h1);
        wr(1'b0, 16'h0001);
        wr(1'b1, 16'h0000);
        pwr_wr = 1'b1; @(negedge clk); pwr_wr = 1'b0;
        check("R5 reissued pulse", {15'b0, pwr_change}, 16'h1);
        wr(1'b0, 16'h0001);
    endtask

    task automatic t_ms64();
        logic [15:0] v;
        ticks(MS64);
        rd(1'b0, v); check("R9 idle while disabled", v, 16'h0000);
        wr(1'b1, 16'h0010);
        ticks(MS64 - 1);
        rd(1'b0, v); check("R9 not yet", v, 16'h0000);
        ticks(1);
        rd(1'b0, v); check("R9 expiry sets bit4", v, 16'h0010);
        wr(1'b0, 16'h0010);
        ticks(MS64);
        rd(1'b0, v); check("R9 keeps running", v, 16'h0010);
        wr(1'b0, 16'h0010);
        ticks(5);
        wr(1'b1, 16'h0000);
        wr(1'b1, 16'h0010);
        ticks(MS64 - 1);
        rd(1'b0, v); check("R9 count cleared while disabled", v, 16'h0000);
        ticks(1);
        rd(1'b0, v); check("R9 full period after re-enable", v, 16'h0010);
        wr(1'b1, 16'h0000);
        wr(1'b0, 16'h0010);
    endtask

    task automatic t_minute();
        logic [15:0] v;
        full_on = 1'b1; @(negedge clk);
        ticks(MINT - 1);
        rd(1'b0, v); check("R10 not yet", v, 16'h0000);
        ticks(1);
        rd(1'b0, v); check("R10 expiry sets bit3", v, 16'h0008);
        wr(1'b0, 16'h0008);
        ticks(7);
        full_on = 1'b0; @(negedge clk);
        full_on = 1'b1; @(negedge clk);
        ticks(MINT - 1);
        rd(1'b0, v); check("R10 cleared outside full-on", v, 16'h0000);
        ticks(1);
        rd(1'b0, v); check("R10 period restarts", v, 16'h0008);
        full_on = 1'b0;
        wr(1'b0, 16'h0008);
    endtask

    task automatic t_sticky();
        logic [15:0] v;
        wr(1'b1, 16'h0002);
        rd(1'b1, v); check("R7 set", v, 16'h0002);
        wr(1'b1, 16'h0000);
        rd(1'b1, v); check("R7 write 0 ignored", v, 16'h0002);
        wr(1'b1, 16'h001D);
        rd(1'b1, v); check("R12 others writable, R7 kept", v, 16'h001F);
        wr(1'b1, 16'h0000);
        rd(1'b1, v); check("R7 only sticky bit left", v, 16'h0002);
        do_reset();
        rd(1'b1, v); check("R7 reset clears", v, 16'h0000);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_sirq_smi();
        t_rom();
        t_collision();
        t_sleep();
        t_ms64();
        t_minute();
        t_sticky();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule